// File: doc/BRIEF.md
# Double-Data-Rate Receive Slice with Word Alignment

This block is the receive half of a die-to-die parallel link slice. Sixteen single-ended data lanes, plus an optional pair of sideband lanes (forward-error-correction and auxiliary), arrive with a forwarded clock. Every lane is sampled on both edges of that clock. The two samples from each clock period are shifted into a per-lane history. Every N/2 forwarded-clock cycles, one N-bit word per lane is lifted out of that history and presented on a parallel bus. A divided parallel clock, running at 1/(N/2) of the forwarded clock, comes out with the bus.

After active-low reset is released, the slice assumes that the far transmitter is already sending clock and a repeating training word. It slides its word window across the N possible bit-slip positions until lane 0 shows the training word for a set number of consecutive words. As a fallback, it stops searching when a timer expires. Only then does it raise ready, and it freezes the chosen slip for all lanes. The sideband lanes use the same window and are never interpreted.

The receiver runs when the slice is configured as a receiver (`tx_en` low) or when loopback self-test is requested (`lpbk` high). When the slice is configured as a transmitter without loopback, the receiver is held quiet.

Top module: `rxs_rx_slice`

## Requirements
- R1: While `rst_n` is low, `rdy`, `pclk`, `rx_data`, `rx_fec` and `rx_aux` are all zero.
- R2: Within one forwarded-clock period, the bit sampled on the rising edge comes before the bit sampled on the following falling edge. In each output word, bit N-1 holds the earliest received bit and bit 0 the latest. Lane i of `rx_data` occupies bits [i*N +: N].
- R3: `pclk` is high for N/4 forwarded-clock cycles and low for N/4 cycles. Output words change only at the forwarded-clock edge where `pclk` rises.
- R4: Before ready, the window advances one slip position (wrapping from N-1 to 0) after every lane-0 word that differs from the training word. The default training word is 4'b1100, most significant bit sent first. Ready rises after MATCH_RUN (default 4) consecutive lane-0 words equal the training word, and so no earlier than MATCH_RUN*N/2 cycles after release.
- R5: Once ready, every lane delivers the transmitted words whole, in transmission order, with no word skipped or repeated.
- R6: If no lock occurs, ready rises on exactly the TIMEOUT-th (default 120) rising forwarded-clock edge after reset release.
- R7: Once high, ready stays high and the slip position stays fixed, whatever the lanes carry, until reset or deactivation.
- R8: Asserting `rst_n` low drops ready at once, without waiting for a clock edge. After release, alignment starts over from the search state.
- R9: The FEC and AUX lanes are delivered on `rx_fec` and `rx_aux` with the same slip and word timing as the data lanes, bit for bit, without interpretation.
- R10: With `tx_en` high and `lpbk` low, the receiver is inactive. Ready stays low, `pclk` stays low and all output words are zero, and deactivating a ready receiver drops ready at the next clock edge. With `lpbk` high, the receiver aligns and delivers words as normal even though `tx_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_clk | input | 1 | Forwarded clock from the far transmitter; lanes are sampled on both edges |
| rst_n | input | 1 | Active-low asynchronous reset of the slice |
| tx_en | input | 1 | Slice configured as transmitter; disables the receiver unless loopback is set |
| lpbk | input | 1 | Loopback self-test: keeps the receiver running alongside the local transmitter |
| lane_d | input | 16 | Serial data lanes |
| lane_fec | input | 1 | Serial forward-error-correction lane |
| lane_aux | input | 1 | Serial auxiliary lane |
| pclk | output | 1 | Divided parallel-word clock |
| rx_data | output | 16*N | Deserialized data words, lane i at bits [i*N +: N] |
| rx_fec | output | N | Deserialized FEC lane word |
| rx_aux | output | N | Deserialized AUX lane word |
| rdy | output | 1 | Alignment finished; delivered words are correct |

## Verification
Alignment is exercised with the training stream started at each of the N bit phases relative to the receiver's word boundary. This shows that every slip position can be reached, and that the chosen slip lines up the payload words that follow on all eighteen lanes. The payload gives each lane and each word its own value, so a wrong edge order, a reversed bit order, a lane swap or a dropped or repeated word produces a mismatch. An all-zero stream that can never match separates the timer path from the lock path and pins down the exact release-to-ready count. Reset during ready, and the transmitter-only and loopback settings, show the restart and gating behaviour.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int RXS_CORE_LANES = 16;

  typedef enum logic {
    AL_HUNT   = 1'b0,
    AL_LOCKED = 1'b1
  } al_state_e;

  // total serial lanes carried by one slice
  function automatic int rxs_lane_total(input bit with_side);
    return with_side ? RXS_CORE_LANES + 2 : RXS_CORE_LANES;
  endfunction

  // number of forwarded-clock cycles per parallel word (two bits per cycle)
  function automatic int rxs_cycles_per_word(input int ratio);
    return ratio / 2;
  endfunction

endpackage

// File: rtl/rxs_ddr_cap.sv
module rxs_ddr_cap #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d,
  input  logic [SW-1:0] slip,
  output logic [N-1:0]  word
);
  localparam int HW = 2 * N;

  logic          rise_q;
  logic          fall_q;
  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= d;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= d;

  // rising-edge sample is older than the falling-edge sample that follows it
  assign hist_nx = {hist_q[HW-3:0], rise_q, fall_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nx;

  // newest bit at index 0; slip moves the window towards older bits
  assign word = hist_nx[slip +: N];

endmodule

// File: rtl/rxs_align.sv
module rxs_align
  import rxs_pkg::*;
#(
  parameter int             N         = 4,
  parameter int             MATCH_RUN = 4,
  parameter int             TIMEOUT   = 120,
  parameter logic [N-1:0]   TRAIN     = N'(4'b1100),
  parameter int             SW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          stb,
  input  logic [N-1:0]  word0,
  output logic [SW-1:0] slip,
  output logic          rdy
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(MATCH_RUN + 1);

  al_state_e     state;
  logic [TW-1:0] timer;
  logic [RW-1:0] run;

  logic hunting, is_train, lock_hit, time_hit, slip_step;
  logic [SW-1:0] slip_nx;

  assign hunting   = (state == AL_HUNT) && act;
  assign is_train  = (word0 == TRAIN);
  assign lock_hit  = hunting && stb && is_train && (run == RW'(MATCH_RUN - 1));
  assign time_hit  = hunting && (timer == TW'(TIMEOUT - 1));
  assign slip_step = hunting && stb && !is_train;
  assign slip_nx   = (slip == SW'(N - 1)) ? '0 : slip + SW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= AL_HUNT;
      timer <= '0;
      run   <= '0;
      slip  <= '0;
    end else if (!act) begin
      state <= AL_HUNT;
      timer <= '0;
      run   <= '0;
      slip  <= '0;
    end else if (state == AL_HUNT) begin
      timer <= timer + TW'(1);
      if (lock_hit || time_hit) state <= AL_LOCKED;
      if (stb && is_train) run <= run + RW'(1);
      if (slip_step) begin
        run  <= '0;
        slip <= slip_nx;
      end
    end

  assign rdy = (state == AL_LOCKED);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(MATCH_RUN)); // R4
  AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(lock_hit || time_hit)); // R6
  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && act |=> rdy); // R7
  AST_SLIP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && act |=> $stable(slip)); // R7
  AST_SLIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_step |=> (slip != $past(slip))); // R4

endmodule

// File: rtl/rxs_rx_slice.sv
module rxs_rx_slice
  import rxs_pkg::*;
#(
  parameter int           N         = 4,
  parameter bit           HAS_SIDE  = 1'b1,
  parameter int           MATCH_RUN = 4,
  parameter int           TIMEOUT   = 120,
  parameter logic [N-1:0] TRAIN     = N'(4'b1100)
) (
  input  logic                          fwd_clk,
  input  logic                          rst_n,
  input  logic                          tx_en,
  input  logic                          lpbk,
  input  logic [RXS_CORE_LANES-1:0]     lane_d,
  input  logic                          lane_fec,
  input  logic                          lane_aux,
  output logic                          pclk,
  output logic [RXS_CORE_LANES*N-1:0]   rx_data,
  output logic [N-1:0]                  rx_fec,
  output logic [N-1:0]                  rx_aux,
  output logic                          rdy
);
  localparam int LN   = rxs_lane_total(HAS_SIDE);
  localparam int HALF = rxs_cycles_per_word(N);
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SW   = $clog2(N);

  logic          act;
  logic [LN-1:0] lanes;
  logic [CW-1:0] cnt, cnt_nx;
  logic          stb;
  logic          pclk_q;
  logic [SW-1:0] slip;
  logic [LN*N-1:0] lane_word;
  logic [LN*N-1:0] out_q;

  assign act = !tx_en || lpbk;

  generate
    if (HAS_SIDE) begin : g_side
      assign lanes = {lane_aux, lane_fec, lane_d};
    end else begin : g_core
      assign lanes = lane_d;
    end
  endgenerate

  genvar gi;
  generate
    for (gi = 0; gi < LN; gi++) begin : g_lane
      rxs_ddr_cap #(.N(N), .SW(SW)) u_cap (
        .clk  (fwd_clk),
        .rst_n(rst_n),
        .d    (lanes[gi]),
        .slip (slip),
        .word (lane_word[gi*N +: N])
      );
    end
  endgenerate

  // word phase counter and divided clock
  assign stb    = act && (cnt == CW'(HALF - 1));
  assign cnt_nx = stb ? '0 : cnt + CW'(1);

  always_ff @(posedge fwd_clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      pclk_q <= 1'b0;
      out_q  <= '0;
    end else if (!act) begin
      cnt    <= '0;
      pclk_q <= 1'b0;
      out_q  <= '0;
    end else begin
      cnt    <= cnt_nx;
      pclk_q <= (cnt_nx < CW'(HALF / 2));
      if (stb) out_q <= lane_word;
    end

  rxs_align #(
    .N(N), .MATCH_RUN(MATCH_RUN), .TIMEOUT(TIMEOUT), .TRAIN(TRAIN), .SW(SW)
  ) u_align (
    .clk  (fwd_clk),
    .rst_n(rst_n),
    .act  (act),
    .stb  (stb),
    .word0(lane_word[N-1:0]),
    .slip (slip),
    .rdy  (rdy)
  );

  assign pclk    = pclk_q;
  assign rx_data = out_q[RXS_CORE_LANES*N-1:0];

  generate
    if (HAS_SIDE) begin : g_side_out
      assign rx_fec = out_q[RXS_CORE_LANES*N +: N];
      assign rx_aux = out_q[(RXS_CORE_LANES+1)*N +: N];
    end else begin : g_no_side_out
      assign rx_fec = '0;
      assign rx_aux = '0;
    end
  endgenerate

  AST_WORD_ON_PCLK: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    !$stable(out_q) |-> $rose(pclk_q) || !$past(act)); // R3
  AST_IDLE_QUIET: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    !act |=> !rdy && (out_q == '0) && !pclk_q); // R10
  AST_STB_PCLK: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    stb |=> pclk_q); // R3

endmodule

// File: tb/rxs_rx_slice_tb.sv
module rxs_rx_slice_tb;
  localparam int N = 4;
  localparam int MATCH_RUN = 4;
  localparam int TIMEOUT = 120;
  localparam int M_ZERO = 0, M_TRAIN = 1, M_PAY = 2;

  logic fwd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic lpbk = 1'b0;
  logic [15:0] lane_d = '0;
  logic lane_fec = 1'b0;
  logic lane_aux = 1'b0;
  logic pclk;
  logic [16*N-1:0] rx_data;
  logic [N-1:0] rx_fec, rx_aux;
  logic rdy;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  int sl = 0;
  int cur_mode = M_ZERO;
  int pend_mode = M_ZERO;

  rxs_rx_slice u_dut (
    .fwd_clk(fwd_clk), .rst_n(rst_n), .tx_en(tx_en), .lpbk(lpbk),
    .lane_d(lane_d), .lane_fec(lane_fec), .lane_aux(lane_aux),
    .pclk(pclk), .rx_data(rx_data), .rx_fec(rx_fec), .rx_aux(rx_aux), .rdy(rdy)
  );

  always #10 fwd_clk = ~fwd_clk;

  function automatic logic [3:0] pay(input int w, input int l);
    return 4'((w * 7 + l * 3 + 5) % 16);
  endfunction

  function automatic logic [3:0] lane_out(input int l);
    if (l < 16) return rx_data[l*N +: N];
    else if (l == 16) return rx_fec;
    else return rx_aux;
  endfunction

  // transmitter model: one bit per half period, MSB of each word first
  initial begin
    #5;
    forever begin
      int b;
      b = sl + phase;
      if (b % N == 0) cur_mode = pend_mode;
      for (int l = 0; l < 18; l++) begin
        logic [3:0] wv;
        logic bv;
        case (cur_mode)
          M_TRAIN: wv = 4'b1100;
          M_PAY:   wv = pay(b / N, l);
          default: wv = 4'b0000;
        endcase
        bv = wv[N - 1 - (b % N)];
        if (l < 16) lane_d[l] = bv;
        else if (l == 16) lane_fec = bv;
        else lane_aux = bv;
      end
      sl++;
      #10;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic cyc();
    @(posedge fwd_clk); #1;
  endtask

  task automatic next_word();
    cyc();
    while (!pclk) cyc();
  endtask

  task automatic do_reset();
    @(posedge fwd_clk); #3; rst_n = 1'b0;
    repeat (3) cyc();
  endtask

  task automatic release_rst();
    @(posedge fwd_clk); #3; rst_n = 1'b1;
  endtask

  // count posedges after release until rdy, up to lim
  task automatic wait_rdy(input int lim, output int k);
    k = 0;
    do begin cyc(); k++; end while (!rdy && k < lim);
  endtask

  task automatic check_payload(input string tag);
    int w0;
    bit ok_d, ok_s;
    pend_mode = M_PAY;
    repeat (5) next_word();
    w0 = (7 * (int'(rx_data[3:0]) + 16 - 5)) % 16;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) next_word();
      ok_d = 1'b1; ok_s = 1'b1;
      for (int l = 0; l < 16; l++) if (lane_out(l) != pay(w0 + k, l)) ok_d = 1'b0;
      for (int l = 16; l < 18; l++) if (lane_out(l) != pay(w0 + k, l)) ok_s = 1'b0;
      // R5 and R2: all data lanes in order, MSB earliest
      check(ok_d, "R5", {tag, " data lanes word"}, rx_data[63:56], pay(w0 + k, 15));
      // R9: sideband lanes follow the same window
      check(ok_s, "R9", {tag, " sideband word"}, {rx_aux, rx_fec}, {pay(w0 + k, 17), pay(w0 + k, 16)});
    end
    check(rdy == 1'b1, "R7", {tag, " ready held during payload"}, rdy, 1);
  endtask

  initial begin
    int k;
    // R1: reset state
    pend_mode = M_TRAIN;
    repeat (3) cyc();
    check(!rdy && !pclk && rx_data == '0 && rx_fec == '0 && rx_aux == '0,
          "R1", "outputs in reset", {rdy, pclk}, 0);

    // R4, R5, R9: every starting phase
    for (int p = 0; p < N; p++) begin
      do_reset();
      pend_mode = M_TRAIN;
      phase = p;
      repeat (4) cyc();
      check(!rdy && rx_data == '0, "R1", "held in reset", rdy, 0);
      release_rst();
      wait_rdy(TIMEOUT + 10, k);
      check(rdy && k >= MATCH_RUN * (N / 2) && k < TIMEOUT, "R4",
            "lock cycles after release", k, MATCH_RUN * (N / 2));
      if (p == 0) begin
        // R3: pclk half-period pattern and word change only on pclk rise
        bit ok;
        logic pp;
        logic [63:0] pd;
        ok = 1'b1;
        pend_mode = M_PAY;
        pp = pclk; pd = rx_data;
        for (int c = 0; c < 12; c++) begin
          cyc();
          if (pclk == pp) ok = 1'b0;
          if (rx_data != pd && !(pclk && !pp)) ok = 1'b0;
          pp = pclk; pd = rx_data;
        end
        check(ok, "R3", "pclk toggling and word timing", pclk, pp);
      end
      check_payload($sformatf("phase %0d", p));
    end

    // R6: no lock possible, timer path
    do_reset();
    pend_mode = M_ZERO;
    repeat (4) cyc();
    release_rst();
    wait_rdy(TIMEOUT + 10, k);
    check(rdy && k == TIMEOUT, "R6", "timeout cycle count", k, TIMEOUT);
    repeat (10) cyc();
    check(rdy == 1'b1, "R7", "ready stays after timeout on garbage", rdy, 1);

    // R8: async reset drop and restart
    @(posedge fwd_clk); #3; rst_n = 1'b0; #1;
    check(rdy == 1'b0, "R8", "ready drops without clock edge", rdy, 0);
    check(rx_data == '0, "R1", "data cleared on reset", rx_data, 0);
    pend_mode = M_TRAIN;
    repeat (3) cyc();
    release_rst();
    cyc();
    check(rdy == 1'b0, "R8", "search restarts after release", rdy, 0);
    wait_rdy(TIMEOUT + 10, k);
    check(rdy && k < TIMEOUT, "R8", "relock after restart", k, 0);

    // R10: transmitter-only setting keeps receiver quiet
    do_reset();
    tx_en = 1'b1; lpbk = 1'b0;
    pend_mode = M_TRAIN;
    release_rst();
    begin
      bit ok;
      ok = 1'b1;
      for (int c = 0; c < TIMEOUT + 40; c++) begin
        cyc();
        if (rdy || pclk || rx_data != '0 || rx_fec != '0) ok = 1'b0;
      end
      check(ok, "R10", "inactive receiver quiet", {rdy, pclk}, 0);
    end
    // loopback enables receive with transmitter on
    @(posedge fwd_clk); #3; lpbk = 1'b1;
    wait_rdy(TIMEOUT + 10, k);
    check(rdy && k < TIMEOUT, "R10", "loopback aligns", k, 0);
    check_payload("loopback");
    // deactivate while ready
    @(posedge fwd_clk); #3; lpbk = 1'b0;
    cyc();
    check(!rdy && rx_data == '0, "R10", "deactivation drops ready", rdy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule